// File: doc/BRIEF.md
# Data-Port Address Decoder with Guarded Program-Memory Writes

This block sits on the data port of a small processor. It reduces every data address to 17 bits. When bit 16 of the reduced address is clear, the access is forwarded to a 64 KB data RAM. When bit 16 is set, the address selects one of a handful of IO registers:

- a console character output;
- a debug word strobe;
- a program-exit strobe that carries the value of the processor's register 0;
- a coarse cycle timer that can be read;
- an indirect path that writes into program memory.

The program-memory path is guarded. A key register must first be written with the 32-bit value 0x1337F7D1. An address register is then loaded, and each write to a data register issues one program-memory write request at the stored address. All outputs are registered and appear one clock after the request. The timer is built from a prescaler and counts once every 100 clocks, so reading it returns the elapsed cycle count divided by 100 with no divider hardware.

Top module: `dport_io_decoder`

## Requirements
- R1: Only address bits 16:0 are used. An access with bit 16 clear raises `ram_en` for one cycle with `ram_addr` equal to bits 15:0 after alignment, and with the write flag, size and write data copied. Alignment follows `req_size`: 0 is byte (no change), 1 is halfword (bit 0 cleared), 2 or 3 is word (bits 1:0 cleared).
- R2: A write to 0x10000 raises `console_valid` for one cycle with `console_byte` equal to data bits 7:0.
- R3: A write to 0x1FC80 sets the unlock flag if the data equals 0x1337F7D1 and clears it for any other value.
- R4: A write to 0x1FC84 stores the data as the program-memory address. While unlocked, a write to 0x1FC88 raises `pm_wr_valid` with the stored address aligned as in R1 for the access size, the write data and the size.
- R5: The unlock flag is 0 after reset. A write to 0x1FC88 while locked issues no program-memory write.
- R6: A read of 0x1FFF4 raises `io_rd_valid` with `io_rd_data` equal to floor(n/100), where n is the number of clocks since reset was released before the read was presented.
- R7: A write to 0x1FFFC raises `exit_valid` with `exit_code` equal to `reg0_in`.
- R8: A write to 0x1FFF8 raises `debug_valid` with `debug_word` equal to the write data.
- R9: A read of any IO address other than 0x1FFF4 raises `illegal_read` and no other strobe.
- R10: A write to any IO address not listed in R2–R4, R7 and R8 (the timer address included) raises only `unknown_write` and changes no state.
- R11: Each accepted request raises exactly one of the output strobes (except key and address writes, which raise none) one clock later, for one cycle. No strobe is raised without a request, and all strobes are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Data-port request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 32 | Data address (bits 31:17 ignored) |
| req_wdata | input | 32 | Write data |
| reg0_in | input | 32 | Processor register 0, used as exit code |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write flag |
| ram_size | output | 2 | RAM access size |
| ram_addr | output | 16 | Aligned RAM byte address |
| ram_wdata | output | 32 | RAM write data |
| console_valid | output | 1 | Console character strobe |
| console_byte | output | 8 | Console character |
| debug_valid | output | 1 | Debug word strobe |
| debug_word | output | 32 | Debug word |
| exit_valid | output | 1 | Program exit strobe |
| exit_code | output | 32 | Exit code |
| pm_wr_valid | output | 1 | Program-memory write request |
| pm_wr_addr | output | 32 | Aligned program-memory address |
| pm_wr_size | output | 2 | Program-memory write size |
| pm_wr_data | output | 32 | Program-memory write data |
| io_rd_valid | output | 1 | Timer read data valid |
| io_rd_data | output | 32 | Timer value |
| illegal_read | output | 1 | Read of an unmapped IO address |
| unknown_write | output | 1 | Write to an unmapped IO address |

## Verification
A wrong unlock flag is only visible on the next write to the data register. There it shows up either as a missing `pm_wr_valid` or as a program-memory write that should not have happened, so the bench tries such writes right after each key change. A stale address register shows up as a wrong `pm_wr_addr` on the next unlocked write. A prescaler that is off by one cycle shows up only when the timer is read exactly at a multiple of 100 cycles, so reads are made on both sides of the first two boundaries. A misdecoded address shows up one clock later as the wrong strobe.

// File: rtl/dport_io_pkg.sv
package dport_io_pkg;

  localparam int IO_AW = 17;

  localparam logic [IO_AW-1:0] A_CONSOLE = 17'h10000;
  localparam logic [IO_AW-1:0] A_KEY     = 17'h1FC80;
  localparam logic [IO_AW-1:0] A_PMADDR  = 17'h1FC84;
  localparam logic [IO_AW-1:0] A_PMDATA  = 17'h1FC88;
  localparam logic [IO_AW-1:0] A_TIMER   = 17'h1FFF4;
  localparam logic [IO_AW-1:0] A_DEBUG   = 17'h1FFF8;
  localparam logic [IO_AW-1:0] A_EXIT    = 17'h1FFFC;

  typedef enum logic [3:0] {
    T_RAM, T_CONSOLE, T_KEY, T_PMADDR, T_PMDATA,
    T_TIMER, T_DEBUG, T_EXIT, T_OTHER
  } io_target_e;

  // low address bits dropped for a given access size
  function automatic logic [1:0] low_clear(input logic [1:0] size);
    case (size)
      2'd0:    low_clear = 2'b00;
      2'd1:    low_clear = 2'b01;
      default: low_clear = 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/dport_addr_decode.sv
module dport_addr_decode
  import dport_io_pkg::*;
(
  input  logic [IO_AW-1:0] addr,
  output io_target_e       target
);
  always_comb begin
    if (!addr[IO_AW-1]) begin
      target = T_RAM;
    end else begin
      case (addr)
        A_CONSOLE: target = T_CONSOLE;
        A_KEY:     target = T_KEY;
        A_PMADDR:  target = T_PMADDR;
        A_PMDATA:  target = T_PMDATA;
        A_TIMER:   target = T_TIMER;
        A_DEBUG:   target = T_DEBUG;
        A_EXIT:    target = T_EXIT;
        default:   target = T_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/dport_tick_timer.sv
module dport_tick_timer #(
  parameter int DIV    = 100,
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [TICK_W-1:0] tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre  <= '0;
      tick <= '0;
    end else if (pre == LAST) begin
      pre  <= '0;
      tick <= tick + 1'b1;
    end else begin
      pre  <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/dport_pm_guard.sv
module dport_pm_guard
  import dport_io_pkg::*;
#(
  parameter int          AW  = 32,
  parameter int          DW  = 32,
  parameter logic [DW-1:0] KEY = 32'h1337F7D1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_we,
  input  logic          addr_we,
  input  logic          data_we,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    size,
  output logic          unlocked,
  output logic          pm_wr_valid,
  output logic [AW-1:0] pm_wr_addr,
  output logic [1:0]    pm_wr_size,
  output logic [DW-1:0] pm_wr_data
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked    <= 1'b0;
      addr_q      <= '0;
      pm_wr_valid <= 1'b0;
      pm_wr_addr  <= '0;
      pm_wr_size  <= '0;
      pm_wr_data  <= '0;
    end else begin
      pm_wr_valid <= data_we && unlocked;
      if (key_we)  unlocked <= (wdata == KEY);
      if (addr_we) addr_q   <= AW'(wdata);
      if (data_we && unlocked) begin
        pm_wr_addr <= addr_q & ~{{(AW-2){1'b0}}, low_clear(size)};
        pm_wr_size <= size;
        pm_wr_data <= wdata;
      end
    end
  end
endmodule

// File: rtl/dport_io_decoder.sv
module dport_io_decoder
  import dport_io_pkg::*;
#(
  parameter int            ADDR_W = 32,
  parameter int            DATA_W = 32,
  parameter int            RAM_AW = 16,
  parameter int            DIV    = 100,
  parameter int            TICK_W = 32,
  parameter logic [31:0]   KEY    = 32'h1337F7D1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] reg0_in,
  output logic              ram_en,
  output logic              ram_we,
  output logic [1:0]        ram_size,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              console_valid,
  output logic [7:0]        console_byte,
  output logic              debug_valid,
  output logic [DATA_W-1:0] debug_word,
  output logic              exit_valid,
  output logic [DATA_W-1:0] exit_code,
  output logic              pm_wr_valid,
  output logic [ADDR_W-1:0] pm_wr_addr,
  output logic [1:0]        pm_wr_size,
  output logic [DATA_W-1:0] pm_wr_data,
  output logic              io_rd_valid,
  output logic [DATA_W-1:0] io_rd_data,
  output logic              illegal_read,
  output logic              unknown_write
);
  io_target_e         target;
  logic               wr, rd;
  logic               unlocked;
  logic [TICK_W-1:0]  tick;
  logic               unused_hi;

  assign unused_hi = ^req_addr[ADDR_W-1:IO_AW];
  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  dport_addr_decode u_dec (
    .addr   (req_addr[IO_AW-1:0]),
    .target (target)
  );

  dport_tick_timer #(.DIV(DIV), .TICK_W(TICK_W)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  dport_pm_guard #(.AW(ADDR_W), .DW(DATA_W), .KEY(DATA_W'(KEY))) u_guard (
    .clk         (clk),
    .rst         (rst),
    .key_we      (wr && target == T_KEY),
    .addr_we     (wr && target == T_PMADDR),
    .data_we     (wr && target == T_PMDATA),
    .wdata       (req_wdata),
    .size        (req_size),
    .unlocked    (unlocked),
    .pm_wr_valid (pm_wr_valid),
    .pm_wr_addr  (pm_wr_addr),
    .pm_wr_size  (pm_wr_size),
    .pm_wr_data  (pm_wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_en        <= 1'b0;
      ram_we        <= 1'b0;
      ram_size      <= '0;
      ram_addr      <= '0;
      ram_wdata     <= '0;
      console_valid <= 1'b0;
      console_byte  <= '0;
      debug_valid   <= 1'b0;
      debug_word    <= '0;
      exit_valid    <= 1'b0;
      exit_code     <= '0;
      io_rd_valid   <= 1'b0;
      io_rd_data    <= '0;
      illegal_read  <= 1'b0;
      unknown_write <= 1'b0;
    end else begin
      ram_en        <= req_valid && target == T_RAM;
      console_valid <= wr && target == T_CONSOLE;
      debug_valid   <= wr && target == T_DEBUG;
      exit_valid    <= wr && target == T_EXIT;
      io_rd_valid   <= rd && target == T_TIMER;
      illegal_read  <= rd && target != T_RAM && target != T_TIMER;
      unknown_write <= wr && (target == T_TIMER || target == T_OTHER);
      if (req_valid && target == T_RAM) begin
        ram_we    <= req_write;
        ram_size  <= req_size;
        ram_addr  <= req_addr[RAM_AW-1:0] &
                     ~{{(RAM_AW-2){1'b0}}, low_clear(req_size)};
        ram_wdata <= req_wdata;
      end
      if (wr && target == T_CONSOLE) console_byte <= req_wdata[7:0];
      if (wr && target == T_DEBUG)   debug_word   <= req_wdata;
      if (wr && target == T_EXIT)    exit_code    <= reg0_in;
      if (rd && target == T_TIMER)   io_rd_data   <= DATA_W'(tick);
    end
  end
endmodule

// File: rtl/dport_io_checker.sv
module dport_io_checker #(
  parameter int          TICK_W = 32,
  parameter logic [31:0] KEY    = 32'h1337F7D1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [31:0]       req_addr,
  input logic [31:0]       req_wdata,
  input logic              ram_en,
  input logic              console_valid,
  input logic [7:0]        console_byte,
  input logic              debug_valid,
  input logic              exit_valid,
  input logic              pm_wr_valid,
  input logic              io_rd_valid,
  input logic              illegal_read,
  input logic              unknown_write,
  input logic              unlocked,
  input logic [TICK_W-1:0] tick
);
  logic [7:0] strobes;
  assign strobes = {ram_en, console_valid, debug_valid, exit_valid,
                    pm_wr_valid, io_rd_valid, illegal_read, unknown_write};

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (strobes == 8'd0));

  p_ram_path_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_addr[16]) |=> ram_en);

  p_io_not_ram_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[16]) |=> !ram_en);

  p_console_byte_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[16:0] == 17'h10000)
      |=> (console_valid && console_byte == $past(req_wdata[7:0])));

  p_key_opens_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[16:0] == 17'h1FC80 && req_wdata == KEY)
      |=> unlocked);

  p_locked_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[16:0] == 17'h1FC88 && !unlocked)
      |=> !pm_wr_valid);

  p_tick_step_r6: assert property (@(posedge clk) disable iff (rst)
    (tick == $past(tick)) || (tick == $past(tick) + 1'b1));
endmodule

bind dport_io_decoder dport_io_checker #(.TICK_W(TICK_W), .KEY(KEY)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_addr      (32'(req_addr)),
  .req_wdata     (32'(req_wdata)),
  .ram_en        (ram_en),
  .console_valid (console_valid),
  .console_byte  (console_byte),
  .debug_valid   (debug_valid),
  .exit_valid    (exit_valid),
  .pm_wr_valid   (pm_wr_valid),
  .io_rd_valid   (io_rd_valid),
  .illegal_read  (illegal_read),
  .unknown_write (unknown_write),
  .unlocked      (unlocked),
  .tick          (tick)
);

// File: tb/sim_dport_io_decoder.sv
module sim_dport_io_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1337F7D1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_addr = '0, req_wdata = '0, reg0_in = '0;
  logic        ram_en, ram_we, console_valid, debug_valid, exit_valid;
  logic        pm_wr_valid, io_rd_valid, illegal_read, unknown_write;
  logic [1:0]  ram_size, pm_wr_size;
  logic [15:0] ram_addr;
  logic [7:0]  console_byte;
  logic [31:0] ram_wdata, debug_word, exit_code, pm_wr_addr, pm_wr_data, io_rd_data;

  int total = 0, bad = 0;
  int cyc = 0;
  bit done = 0;
  bit m_unlocked = 0;
  logic [31:0] m_pmaddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  dport_io_decoder u0 (.*);

  function automatic logic [31:0] aligned(input logic [1:0] s, input logic [31:0] a);
    if (s == 2'd0) return a;
    if (s == 2'd1) return a & 32'hFFFF_FFFE;
    return a & 32'hFFFF_FFFC;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request presented at a falling edge, checked at the next one
  task automatic run(input bit w, input logic [1:0] s, input logic [31:0] a,
                     input logic [31:0] d, input logic [31:0] r0);
    logic [16:0] a17 = a[16:0];
    logic [7:0] e = 8'd0;  // {ram,con,dbg,exit,pm,rd,ill,unk}
    string tag = "R11";
    int tmr = cyc / 100;
    bit pm_ok = m_unlocked;
    logic [31:0] pa = m_pmaddr;
    req_valid = 1; req_write = w; req_size = s; req_addr = a;
    req_wdata = d; reg0_in = r0;
    if (!a17[16]) begin e[7] = 1; tag = "R1"; end
    else if (w) begin
      case (a17)
        17'h10000: begin e[6] = 1; tag = "R2"; end
        17'h1FC80: begin m_unlocked = (d == KEY); tag = "R3"; end
        17'h1FC84: begin m_pmaddr = d; tag = "R4"; end
        17'h1FC88: begin e[3] = pm_ok; tag = pm_ok ? "R4" : "R5"; end
        17'h1FFF8: begin e[5] = 1; tag = "R8"; end
        17'h1FFFC: begin e[4] = 1; tag = "R7"; end
        default:   begin e[0] = 1; tag = "R10"; end
      endcase
    end else if (a17 == 17'h1FFF4) begin e[2] = 1; tag = "R6"; end
    else begin e[1] = 1; tag = "R9"; end
    @(negedge clk);
    chk({tag, " strobes"}, 32'({ram_en, console_valid, debug_valid, exit_valid,
        pm_wr_valid, io_rd_valid, illegal_read, unknown_write}), 32'(e));
    if (e[7]) begin
      chk("R1 addr", 32'(ram_addr), aligned(s, {16'd0, a[15:0]}));
      chk("R1 we/size", {30'd0, ram_we, 1'b0} | 32'(ram_size) << 4, {30'd0, w, 1'b0} | 32'(s) << 4);
      chk("R1 wdata", ram_wdata, d);
    end
    if (e[6]) chk("R2 byte", 32'(console_byte), 32'(d[7:0]));
    if (e[5]) chk("R8 word", debug_word, d);
    if (e[4]) chk("R7 code", exit_code, r0);
    if (e[3]) begin
      chk("R4 addr", pm_wr_addr, aligned(s, pa));
      chk("R4 data", pm_wr_data, d);
      chk("R4 size", 32'(pm_wr_size), 32'(s));
    end
    if (e[2]) chk("R6 timer", io_rd_data, 32'(tmr));
  endtask

  task automatic idle();
    req_valid = 0;
  endtask

  task automatic wait_to(input int n);
    idle();
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 reset strobes", 32'({ram_en, console_valid, debug_valid, exit_valid,
        pm_wr_valid, io_rd_valid, illegal_read, unknown_write}), 32'd0);
    // R5: locked after reset
    run(1, 2, 32'h0001_FC84, 32'h0000_0100, 0);
    run(1, 2, 32'h0001_FC88, 32'hAAAA_5555, 0);
    // R3/R4: unlock and write, alignment per size
    run(1, 2, 32'h0001_FC80, KEY, 0);
    run(1, 2, 32'h0001_FC84, 32'h0000_0123, 0);
    run(1, 2, 32'h0001_FC88, 32'hDEAD_BEEF, 0);
    run(1, 1, 32'h0001_FC88, 32'h0000_BEEF, 0);
    run(1, 0, 32'h0001_FC88, 32'h0000_00EF, 0);
    // R3: wrong key locks again, R5 suppression
    run(1, 2, 32'h0001_FC80, KEY ^ 32'h1, 0);
    run(1, 2, 32'h0001_FC88, 32'h1234_5678, 0);
    // R2, R7, R8, R9, R10, R1 with upper address bits ignored
    run(1, 0, 32'hFFFF_0000, 32'h0000_0141, 0);
    run(1, 2, 32'h0001_FFFC, 32'h0, 32'h0000_002A);
    run(1, 2, 32'h0001_FFF8, 32'hCAFE_F00D, 0);
    run(0, 2, 32'h0001_FC84, 0, 0);
    run(0, 2, 32'h0001_0000, 0, 0);
    run(1, 2, 32'h0001_FFF4, 32'h5, 0);
    run(1, 2, 32'h0001_2344, 32'h7, 0);
    run(1, 1, 32'hABCD_FFFF, 32'h1234_5678, 0);
    run(0, 2, 32'h0000_8003, 0, 0);
    // R6 around the first two boundaries
    wait_to(99);  run(0, 2, 32'h0001_FFF4, 0, 0);
    run(0, 2, 32'h0001_FFF4, 0, 0);
    wait_to(199); run(0, 2, 32'h0001_FFF4, 0, 0);
    run(0, 2, 32'h0001_FFF4, 0, 0);
    idle(); @(negedge clk);
    // R11: no request, no strobe
    chk("R11 idle strobes", 32'({ram_en, console_valid, debug_valid, exit_valid,
        pm_wr_valid, io_rd_valid, illegal_read, unknown_write}), 32'd0);
    // constrained random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, d;
      int pick = $urandom_range(0, 11);
      bit w = $urandom_range(0, 3) != 0;
      logic [1:0] s = 2'($urandom_range(0, 3));
      d = $urandom();
      case (pick)
        0: a = 32'h0001_0000;
        1: begin a = 32'h0001_FC80; if ($urandom_range(0, 1)) d = KEY; end
        2: a = 32'h0001_FC84;
        3, 4: a = 32'h0001_FC88;
        5: a = 32'h0001_FFF4;
        6: a = 32'h0001_FFF8;
        7: a = 32'h0001_FFFC;
        8: a = $urandom() | 32'h0001_0000;
        default: a = $urandom() & 32'hFFFE_FFFF;
      endcase
      if ($urandom_range(0, 4) == 0) idle();
      if ($urandom_range(0, 4) == 0) @(negedge clk);
      run(w, s, a, d, $urandom());
    end
    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule